// File: doc/BRIEF.md
# NAND Flash Register Port

This block sits on a simple processor register bus and lets software operate a raw 8-bit NAND flash device one bus cycle at a time. Software writes a configuration word to switch the port on, pick the chip-enable level and set the strobe width. It then writes command and address bytes and moves data bytes through a data register. Each access to the command, address or data register becomes exactly one NAND bus cycle. The command latch and address latch lines are set to suit the register that was touched.

The bus handshake is held off with a ready signal while a NAND cycle runs. Accesses that only touch local storage finish in the cycle they are presented. A status register gives software a synchronized view of the device's ready/busy pin, so it can poll for the end of an erase or program operation.

Top module: `nand_port_ctrl`

## Requirements
- R1: The register index is `bus_addr[4:2]`: 0 configuration, 1 command, 2 address, 3 data, 4 status, 5 ECC, and 6 and 7 are unused and read zero. Configuration, command and address read back the last value accepted.
- R2: While configuration bit 15 (port enable) is 0, writes to the command, address and data registers are discarded: no NAND cycle starts and the stored value is unchanged. Configuration writes are always accepted.
- R3: `nand_ce_n` is high when configuration bit 11 is 1 or bit 15 is 0, and low otherwise. `nand_wp_n` equals configuration bit 15, so a disabled port holds the device write-protected.
- R4: An accepted command write stores the full word and performs one write cycle with `nand_cle`=1, `nand_ale`=0 and `bus_wdata[7:0]` on `nand_dq_out`.
- R5: An accepted address write stores the word and performs one write cycle with `nand_cle`=0, `nand_ale`=1 and `bus_wdata[7:0]` on the IO bus.
- R6: An accepted data write performs one write cycle with both latch lines low. A data read, enabled or not, performs one read cycle with both latch lines low. It returns the byte sampled as `nand_re_n` rises, zero-extended, and keeps it in the data register.
- R7: In a NAND cycle the active strobe stays low for (configuration bits [2:0] + 1) clocks, then high for one hold clock. `bus_rdy` is low from the request cycle through the last strobe-low clock, which is (field + 3) clocks, and high in the hold clock.
- R8: `nand_dq_oe` is high one clock before `nand_we_n` falls, during the whole low phase and in the hold clock. It stays low during read cycles. `nand_we_n` and `nand_re_n` are never low together.
- R9: Status bit 0 reports `nand_rb` (1 = ready) after a two-flop synchronizer, and the other status bits are zero. Status and ECC ignore writes, and ECC reads zero.
- R10: After reset all registers are zero, both strobes are high, both latch lines are low, `nand_ce_n` is high, `nand_wp_n` is low and `nand_dq_oe` is low.
- R11: Register-only accesses (configuration, status, ECC, unused, and discarded writes) complete with `bus_rdy` high in the cycle they are presented. `bus_rdy` is high while the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_rdy` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid when `bus_rdy` is high |
| bus_rdy | output | 1 | Access completes in this cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_out | output | IO_W | IO bus output byte |
| nand_dq_oe | output | 1 | IO bus output enable |
| nand_dq_in | input | IO_W | IO bus input byte |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |

## Verification
The bench builds the port with its default parameters: a 32-bit register bus, a 6-bit address, an 8-bit IO bus, a 3-bit strobe-width field and a two-stage synchronizer. With the 3-bit field, both extreme strobe widths (one clock and eight clocks) can be programmed from software. The bench measures the `bus_rdy` stall length and the strobe low time at both ends. The two-stage default makes the status latency exactly two clocks, which the bench checks edge by edge.

// File: rtl/nandp_pkg.sv
package nandp_pkg;

   // register index taken from bus_addr[4:2]
   typedef enum logic [2:0] {
      REG_CFG = 3'd0,
      REG_CMD = 3'd1,
      REG_ADR = 3'd2,
      REG_DAT = 3'd3,
      REG_STS = 3'd4,
      REG_ECC = 3'd5
   } reg_idx_e;

   // kind of NAND bus cycle being run
   typedef enum logic [1:0] {
      KIND_CMD    = 2'd0,
      KIND_ADR    = 2'd1,
      KIND_DAT_WR = 2'd2,
      KIND_DAT_RD = 2'd3
   } cyc_kind_e;

   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_SETUP  = 2'd1,
      CYC_STROBE = 2'd2,
      CYC_HOLD   = 2'd3
   } cyc_state_e;

   localparam int NUM_STORED = 4;   // cfg, cmd, adr, dat hold state

endpackage

// File: rtl/nandp_sync.sv
module nandp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nandp_cycle.sv
module nandp_cycle
   import nandp_pkg::*;
#(
   parameter int IO_W = 8,
   parameter int TW_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  cyc_kind_e       kind,
   input  logic [IO_W-1:0] wbyte,
   input  logic [TW_W-1:0] width,
   input  logic [IO_W-1:0] io_in,
   output logic            idle,
   output logic            done,
   output logic            rd_done,
   output logic [IO_W-1:0] rbyte,
   output logic            we_n,
   output logic            re_n,
   output logic            cle,
   output logic            ale,
   output logic            oe,
   output logic [IO_W-1:0] io_out
);

   cyc_state_e      state_q;
   cyc_kind_e       kind_q;
   logic [TW_W-1:0] cnt_q;
   logic [IO_W-1:0] byte_q;
   logic [IO_W-1:0] rbyte_q;
   logic            we_n_q, re_n_q, cle_q, ale_q, oe_q;
   logic            is_rd_q;

   assign is_rd_q = (kind_q == KIND_DAT_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CYC_IDLE;
         kind_q  <= KIND_CMD;
         cnt_q   <= '0;
         byte_q  <= '0;
         rbyte_q <= '0;
         we_n_q  <= 1'b1;
         re_n_q  <= 1'b1;
         cle_q   <= 1'b0;
         ale_q   <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            CYC_IDLE: begin
               if (start) begin
                  state_q <= CYC_SETUP;
                  kind_q  <= kind;
                  byte_q  <= wbyte;
                  cnt_q   <= width;
                  cle_q   <= (kind == KIND_CMD);
                  ale_q   <= (kind == KIND_ADR);
                  oe_q    <= (kind != KIND_DAT_RD);
               end
            end
            CYC_SETUP: begin
               state_q <= CYC_STROBE;
               if (is_rd_q) re_n_q <= 1'b0;
               else         we_n_q <= 1'b0;
            end
            CYC_STROBE: begin
               if (cnt_q == '0) begin
                  state_q <= CYC_HOLD;
                  we_n_q  <= 1'b1;
                  re_n_q  <= 1'b1;
                  if (is_rd_q) rbyte_q <= io_in;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CYC_HOLD: begin
               state_q <= CYC_IDLE;
               cle_q   <= 1'b0;
               ale_q   <= 1'b0;
               oe_q    <= 1'b0;
            end
            default: state_q <= CYC_IDLE;
         endcase
      end
   end

   assign idle    = (state_q == CYC_IDLE);
   assign done    = (state_q == CYC_HOLD);
   assign rd_done = done && is_rd_q;
   assign rbyte   = rbyte_q;
   assign we_n    = we_n_q;
   assign re_n    = re_n_q;
   assign cle     = cle_q;
   assign ale     = ale_q;
   assign oe      = oe_q;
   assign io_out  = byte_q;

endmodule

// File: rtl/nandp_regs.sv
module nandp_regs
   import nandp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IO_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  reg_idx_e          idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ld_en,
   input  logic [IO_W-1:0]   ld_byte,
   input  logic              sts_rb,
   output logic [DATA_W-1:0] cfg,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - IO_W;

   logic [NUM_STORED-1:0][DATA_W-1:0] rf_q;
   logic [DATA_W-1:0]                 ld_word;

   assign ld_word = {{PAD_W{1'b0}}, ld_byte};

   generate
      for (genvar i = 0; i < NUM_STORED; i++) begin : g_reg
         if (i == int'(REG_DAT)) begin : g_dat
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                             rf_q[i] <= '0;
               else if (ld_en)                         rf_q[i] <= ld_word;
               else if (we && idx == reg_idx_e'(i))    rf_q[i] <= wdata;
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                             rf_q[i] <= '0;
               else if (we && idx == reg_idx_e'(i))    rf_q[i] <= wdata;
            end
         end
      end
   endgenerate

   assign cfg = rf_q[int'(REG_CFG)];

   always_comb begin
      unique case (idx)
         REG_CFG: rdata = rf_q[int'(REG_CFG)];
         REG_CMD: rdata = rf_q[int'(REG_CMD)];
         REG_ADR: rdata = rf_q[int'(REG_ADR)];
         REG_DAT: rdata = ld_en ? ld_word : rf_q[int'(REG_DAT)];
         REG_STS: rdata = {{(DATA_W-1){1'b0}}, sts_rb};
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/nand_port_ctrl.sv
module nand_port_ctrl
   import nandp_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int IO_W        = 8,
   parameter int TW_W        = 3,
   parameter int SYNC_STAGES = 2,
   parameter int EN_BIT      = 15,
   parameter int CE_BIT      = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdy,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_ce_n,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic              nand_wp_n,
   output logic [IO_W-1:0]   nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [IO_W-1:0]   nand_dq_in,
   input  logic              nand_rb
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover bits [4:2]");
      end
      if (IO_W < 1 || IO_W >= DATA_W) begin : g_bad_io
         $error("IO_W must be between 1 and DATA_W-1");
      end
      if (TW_W < 1 || TW_W > 8) begin : g_bad_tw
         $error("TW_W must be between 1 and 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (EN_BIT >= DATA_W || CE_BIT >= DATA_W || EN_BIT == CE_BIT) begin : g_bad_bits
         $error("EN_BIT and CE_BIT must be distinct bits of DATA_W");
      end
      if (TW_W > CE_BIT || TW_W > EN_BIT) begin : g_bad_overlap
         $error("strobe width field overlaps a control bit");
      end
   endgenerate

   reg_idx_e          idx;
   logic [DATA_W-1:0] cfg;
   logic              port_en;
   logic              nand_reg;
   logic              nand_wr;
   logic              nand_rd;
   logic              nand_req;
   logic              reg_we;
   logic              cyc_start;
   cyc_kind_e         cyc_kind;
   logic              cyc_idle, cyc_done, cyc_rd_done;
   logic [IO_W-1:0]   cyc_rbyte;
   logic              rb_sync;
   logic              addr_unused;

   assign idx         = reg_idx_e'(bus_addr[4:2]);
   assign addr_unused = ^{bus_addr[ADDR_W-1:5], bus_addr[1:0]};
   assign port_en     = cfg[EN_BIT];

   assign nand_reg = (idx == REG_CMD) || (idx == REG_ADR) || (idx == REG_DAT);
   assign nand_wr  = bus_wr && port_en && nand_reg;
   assign nand_rd  = !bus_wr && (idx == REG_DAT);
   assign nand_req = bus_sel && (nand_wr || nand_rd);

   assign cyc_start = nand_req && cyc_idle;
   assign reg_we    = bus_sel && bus_wr && cyc_idle &&
                      ((idx == REG_CFG) || nand_wr);

   always_comb begin
      unique case (idx)
         REG_CMD: cyc_kind = KIND_CMD;
         REG_ADR: cyc_kind = KIND_ADR;
         default: cyc_kind = bus_wr ? KIND_DAT_WR : KIND_DAT_RD;
      endcase
   end

   nandp_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rb),
      .q     (rb_sync)
   );

   nandp_cycle #(
      .IO_W (IO_W),
      .TW_W (TW_W)
   ) u_cycle (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cyc_start),
      .kind    (cyc_kind),
      .wbyte   (bus_wdata[IO_W-1:0]),
      .width   (cfg[TW_W-1:0]),
      .io_in   (nand_dq_in),
      .idle    (cyc_idle),
      .done    (cyc_done),
      .rd_done (cyc_rd_done),
      .rbyte   (cyc_rbyte),
      .we_n    (nand_we_n),
      .re_n    (nand_re_n),
      .cle     (nand_cle),
      .ale     (nand_ale),
      .oe      (nand_dq_oe),
      .io_out  (nand_dq_out)
   );

   nandp_regs #(
      .DATA_W (DATA_W),
      .IO_W   (IO_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .idx     (idx),
      .wdata   (bus_wdata),
      .ld_en   (cyc_rd_done),
      .ld_byte (cyc_rbyte),
      .sts_rb  (rb_sync),
      .cfg     (cfg),
      .rdata   (bus_rdata)
   );

   assign bus_rdy   = cyc_done || (cyc_idle && !nand_req);
   assign nand_ce_n = cfg[CE_BIT] || !port_en;
   assign nand_wp_n = port_en;

endmodule

// File: rtl/nandp_chk.sv
module nandp_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_rdy,
   input logic nand_cle,
   input logic nand_ale,
   input logic nand_ce_n,
   input logic nand_we_n,
   input logic nand_re_n,
   input logic nand_wp_n,
   input logic nand_dq_oe
);

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R8
   oe_during_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_dq_oe);

   // R8
   oe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> $past(nand_dq_oe));

   // R8
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> nand_dq_oe);

   // R8
   no_oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

   // R4
   latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R7
   stall_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> !bus_rdy);

   // R6
   stall_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !bus_rdy);

   // R7
   hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(nand_we_n) || $rose(nand_re_n)) |-> bus_rdy);

   // R3
   protect_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_wp_n |-> nand_ce_n);

endmodule

bind nand_port_ctrl nandp_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_rdy    (bus_rdy),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_ce_n  (nand_ce_n),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_wp_n  (nand_wp_n),
   .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_port_ctrl_tb_top.sv
module nand_port_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rdy;
   logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_wp_n;
   logic [7:0]  nand_dq_out;
   logic        nand_dq_oe;
   logic [7:0]  nand_dq_in = 8'hA5;
   logic        nand_rb = 1'b1;

   always #4 clk = ~clk;   // 125 MHz

   nand_port_ctrl dut_i (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rdy (bus_rdy),
      .nand_cle (nand_cle), .nand_ale (nand_ale), .nand_ce_n (nand_ce_n),
      .nand_we_n (nand_we_n), .nand_re_n (nand_re_n), .nand_wp_n (nand_wp_n),
      .nand_dq_out (nand_dq_out), .nand_dq_oe (nand_dq_oe),
      .nand_dq_in (nand_dq_in), .nand_rb (nand_rb)
   );

   int checks = 0;
   int errs   = 0;
   bit done_flag = 0;

   // monitor of the NAND side
   bit         mon_en = 0;
   int         wr_cyc = 0, rd_cyc = 0, we_low = 0, re_low = 0;
   logic       m_cle, m_ale, m_oe;
   logic [7:0] m_byte;

   always @(negedge clk) if (mon_en) begin
      if (!nand_we_n) we_low++;
      if (!nand_re_n) re_low++;
   end
   always @(posedge nand_we_n) if (mon_en) begin
      wr_cyc++; m_cle = nand_cle; m_ale = nand_ale; m_oe = nand_dq_oe; m_byte = nand_dq_out;
   end
   always @(posedge nand_re_n) if (mon_en) begin
      rd_cyc++; m_cle = nand_cle; m_ale = nand_ale; m_oe = nand_dq_oe;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // one bus access; returns read data and number of stalled cycles
   task automatic acc(input logic wr, input logic [2:0] idx, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = {1'b0, idx, 2'b00}; bus_wdata = wd;
      waits = 0;
      forever begin
         #1;
         if (bus_rdy) begin rd = bus_rdata; break; end
         waits++;
         @(negedge clk);
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   typedef struct packed {
      logic [3:0]  req;
      logic        wr;
      logic [2:0]  idx;
      logic [31:0] wd;
      logic [31:0] ex;
      logic        cyc;
      logic        cle;
      logic        ale;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{4'd10, 1'b0, 3'd0, 32'h0,        32'h0,     1'b0, 1'b0, 1'b0}, // R10 cfg clear
      '{4'd2,  1'b1, 3'd1, 32'h70,       32'h0,     1'b0, 1'b0, 1'b0}, // R2 discarded
      '{4'd2,  1'b0, 3'd1, 32'h0,        32'h0,     1'b0, 1'b0, 1'b0}, // R2 unchanged
      '{4'd1,  1'b1, 3'd0, 32'h8002,     32'h0,     1'b0, 1'b0, 1'b0}, // R1 enable, width 2
      '{4'd1,  1'b0, 3'd0, 32'h0,        32'h8002,  1'b0, 1'b0, 1'b0}, // R1
      '{4'd4,  1'b1, 3'd1, 32'h1FF,      32'h0,     1'b1, 1'b1, 1'b0}, // R4 command
      '{4'd1,  1'b0, 3'd1, 32'h0,        32'h1FF,   1'b0, 1'b0, 1'b0}, // R1
      '{4'd5,  1'b1, 3'd2, 32'h12,       32'h0,     1'b1, 1'b0, 1'b1}, // R5 address
      '{4'd1,  1'b0, 3'd2, 32'h0,        32'h12,    1'b0, 1'b0, 1'b0}, // R1
      '{4'd6,  1'b1, 3'd3, 32'h3C,       32'h0,     1'b1, 1'b0, 1'b0}, // R6 data write
      '{4'd9,  1'b1, 3'd4, 32'hFFFFFFFF, 32'h0,     1'b0, 1'b0, 1'b0}, // R9 status write
      '{4'd9,  1'b0, 3'd4, 32'h0,        32'h1,     1'b0, 1'b0, 1'b0}, // R9 ready
      '{4'd9,  1'b1, 3'd5, 32'hDEAD,     32'h0,     1'b0, 1'b0, 1'b0}, // R9 ecc write
      '{4'd9,  1'b0, 3'd5, 32'h0,        32'h0,     1'b0, 1'b0, 1'b0}, // R9 ecc reads 0
      '{4'd6,  1'b0, 3'd3, 32'h0,        32'hA5,    1'b1, 1'b0, 1'b0}, // R6 data read
      '{4'd1,  1'b0, 3'd6, 32'h0,        32'h0,     1'b0, 1'b0, 1'b0}  // R1 unused
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin : stim
      logic [31:0] rd;
      int          w;
      int          wc0, rc0, wl0, rl0;
      string       tag;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state at the ports
      chk("R10 we_n", nand_we_n, 1);
      chk("R10 re_n", nand_re_n, 1);
      chk("R10 cle/ale", {nand_cle, nand_ale}, 0);
      chk("R10 ce_n", nand_ce_n, 1);
      chk("R10 wp_n", nand_wp_n, 0);
      chk("R10 oe", nand_dq_oe, 0);
      rst_n = 1'b1;
      mon_en = 1;
      @(negedge clk); #1;
      chk("R11 idle rdy", bus_rdy, 1);

      for (int i = 0; i < NV; i++) begin
         wc0 = wr_cyc; rc0 = rd_cyc; wl0 = we_low; rl0 = re_low;
         acc(VEC[i].wr, VEC[i].idx, VEC[i].wd, rd, w);
         tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
         if (!VEC[i].wr) chk({tag, " rdata"}, rd, VEC[i].ex);
         chk({tag, " cycles"}, (wr_cyc - wc0) + (rd_cyc - rc0), VEC[i].cyc);
         // R7 stall length with width field 2, R11 no stall otherwise
         chk({tag, " R7/R11 waits"}, w, VEC[i].cyc ? 5 : 0);
         if (VEC[i].cyc) begin
            chk({tag, " latch"}, {m_cle, m_ale}, {VEC[i].cle, VEC[i].ale});
            chk({tag, " R8 oe"}, m_oe, VEC[i].wr);
            chk({tag, " R7 strobe low"}, VEC[i].wr ? (we_low - wl0) : (re_low - rl0), 3);
            if (VEC[i].wr) chk({tag, " byte"}, m_byte, VEC[i].wd[7:0]);
         end
      end

      // R3 chip enable and write protect
      chk("R3 ce_n enabled", nand_ce_n, 0);
      chk("R3 wp_n enabled", nand_wp_n, 1);
      acc(1, 3'd0, 32'h8802, rd, w);
      chk("R3 ce_n bit11", nand_ce_n, 1);
      chk("R3 wp_n bit11", nand_wp_n, 1);

      // R7 narrowest strobe: field 0
      acc(1, 3'd0, 32'h8000, rd, w);
      wl0 = we_low;
      acc(1, 3'd1, 32'h0C, rd, w);
      chk("R7 field0 low", we_low - wl0, 1);
      chk("R7 field0 waits", w, 3);

      // R2 discard while disabled, then readback
      acc(1, 3'd0, 32'h0, rd, w);
      chk("R3 ce_n disabled", nand_ce_n, 1);
      chk("R3 wp_n disabled", nand_wp_n, 0);
      wc0 = wr_cyc;
      acc(1, 3'd1, 32'h55, rd, w);
      acc(1, 3'd3, 32'h66, rd, w);
      chk("R2 no cycle", wr_cyc - wc0, 0);
      acc(1, 3'd0, 32'h8007, rd, w);
      acc(0, 3'd1, 32'h0, rd, w);
      chk("R2 cmd kept", rd, 32'h0C);

      // R7 widest strobe on a read, R6 capture
      nand_dq_in = 8'h5A;
      rl0 = re_low;
      acc(0, 3'd3, 32'h0, rd, w);
      chk("R6 read byte", rd, 32'h5A);
      chk("R7 field7 low", re_low - rl0, 8);
      chk("R7 field7 waits", w, 10);

      // R9 two-flop synchronizer latency
      @(negedge clk);
      nand_rb = 1'b0;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h10;
      #1 chk("R9 sync edge0", bus_rdata, 1);
      @(negedge clk); #1 chk("R9 sync edge1", bus_rdata, 1);
      @(negedge clk); #1 chk("R9 sync edge2", bus_rdata, 0);
      @(negedge clk);
      bus_sel = 1'b0;

      // R10 reset again clears the registers
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10 re-reset wp_n", nand_wp_n, 0);
      acc(0, 3'd0, 32'h0, rd, w);
      chk("R10 cfg after reset", rd, 0);

      finish_run();
   end

endmodule